// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt lines and turns them into two requests for a processor: a normal request and a critical request. Each line has its own configuration bits. One bit inverts the line. One bit chooses edge or level detection. One bit sends the line to the critical request instead of the normal one. An enable mask gates every line. A status register records pending lines. Input n owns status bit 31−n, so input 0 sits in the most significant position.

For the critical path the block also gives a vector address. The vector is a base taken from a configuration register, plus a 512-byte stride times the rank of the first pending critical line. A configuration bit chooses the direction in which lines are ranked.

Software reaches the registers through a plain synchronous port with a 3-bit word offset. A write takes effect on the clock edge where `reg_we` is high. Read data is combinational from the offset. The port carries no data stream, so it has no valid/ready pair and never applies back-pressure: every access completes in its own cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Input n (bit n of `irq_in`) drives status bit 31−n. Status reads at offset 0.
- R2: `irq_norm_o` is high exactly when (status AND enable AND NOT critical-select) was nonzero on the previous cycle.
- R3: `irq_crit_o` is high exactly when (status AND enable AND critical-select) was nonzero on the previous cycle.
- R4: When a trigger bit is 0, the line is level-sensitive. Its status bit equals the polarity-corrected input sampled at the previous edge.
- R5: When a trigger bit is 1, the line is edge-sensitive. Its status bit is set by a 0-to-1 change of the polarity-corrected input between two consecutive samples. It then stays set until software clears it.
- R6: A write to offset 0 clears every status bit written as 1. A level-sensitive line that is still active shows its bit set again after that write.
- R7: A polarity bit of 1 inverts the matching input before detection. Polarity, trigger, critical-select and enable bits use the same bit order as status.
- R8: Offset 5 is read-only and returns status AND enable.
- R9: Offset 7 holds the vector configuration. It stores the written word with bit 1 forced to 0. Bit 0 = 1 ranks lines from status bit 31 downward; bit 0 = 0 ranks them from bit 0 upward.
- R10: Offset 6 is read-only and returns the vector: (configuration AND 0xFFFFFFFC) + 512 × rank of the first pending enabled critical line. It reads 0 when no such line is pending. It is registered alongside the outputs.
- R11: Reset clears status, enable, critical-select, polarity, trigger, vector configuration, vector and both outputs to zero.
- R12: Both outputs and the vector change one cycle after the register state that feeds them changes.
- R13: Offsets: 0 status, 1 enable, 2 critical-select, 3 polarity, 4 trigger, 5 masked status, 6 vector, 7 vector configuration. Writes to offsets 5 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines, bit n is input n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from offset |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench targets the places where bit order and timing are easy to get wrong. It checks the reversed mapping from input index to status bit; a design with a straight mapping would give mirrored status and a wrong vector rank. It clears a level line while it is still active and expects the bit to come straight back. It holds edge lines high across clears and expects no re-latch; a design that detected level instead of edge would re-raise the bit. It writes the vector configuration with bit 1 set and with both scan directions. It also runs long random stretches in which configuration writes and input changes land in the same cycle, so an output that is one cycle early or late shows up as a mismatch.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_ENABLE = 3'd1,
    OFS_CRSEL  = 3'd2,
    OFS_POLAR  = 3'd3,
    OFS_TRIG   = 3'd4,
    OFS_MASKED = 3'd5,
    OFS_VECTOR = 3'd6,
    OFS_VCFG   = 3'd7
  } pic_ofs_e;

  localparam int unsigned VEC_STRIDE_LOG2 = 9;

endpackage

// File: rtl/pic_sense.sv
module pic_sense #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] polar,
  input  logic [N_IRQ-1:0] trig,
  input  logic             clr_valid,
  input  logic [N_IRQ-1:0] clr_mask,
  output logic [N_IRQ-1:0] status_o
);

  logic [N_IRQ-1:0] line_rev;
  logic [N_IRQ-1:0] line_corr;
  logic [N_IRQ-1:0] prev_q;
  logic [N_IRQ-1:0] stat_q;
  logic [N_IRQ-1:0] stat_kept;
  logic [N_IRQ-1:0] stat_nxt;

  // input n lands on status bit N_IRQ-1-n
  for (genvar g = 0; g < N_IRQ; g++) begin : g_rev
    assign line_rev[g] = irq_in[N_IRQ-1-g];
  end

  assign line_corr = line_rev ^ polar;
  assign stat_kept = clr_valid ? (stat_q & ~clr_mask) : stat_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    always_comb begin
      if (trig[g]) stat_nxt[g] = stat_kept[g] | (line_corr[g] & ~prev_q[g]);
      else         stat_nxt[g] = line_corr[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= line_corr;
      stat_q <= stat_nxt;
    end
  end

  assign status_o = stat_q;

endmodule

// File: rtl/pic_prio_vec.sv
module pic_prio_vec #(
  parameter int unsigned N_IRQ = 32,
  localparam int unsigned PW = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pending,
  input  logic             scan_down,
  output logic             found,
  output logic [PW-1:0]    rank
);

  logic [N_IRQ-1:0] ordered;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ord
    assign ordered[g] = scan_down ? pending[N_IRQ-1-g] : pending[g];
  end

  always_comb begin
    found = 1'b0;
    rank  = '0;
    for (int j = N_IRQ - 1; j >= 0; j--) begin
      if (ordered[j]) begin
        found = 1'b1;
        rank  = PW'(j);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned AW    = 3,
  localparam int unsigned DW   = N_IRQ,
  localparam int unsigned PW   = $clog2(N_IRQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] irq_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_norm_o,
  output logic          irq_crit_o
);

  logic [DW-1:0] status_q;
  logic [DW-1:0] en_q;
  logic [DW-1:0] crsel_q;
  logic [DW-1:0] polar_q;
  logic [DW-1:0] trig_q;
  logic [DW-1:0] vcfg_q;
  logic [DW-1:0] vec_q;
  logic          norm_q;
  logic          crit_q;

  logic [DW-1:0] masked;
  logic [DW-1:0] crit_pend;
  logic [DW-1:0] norm_pend;
  logic          crit_found;
  logic [PW-1:0] crit_rank;
  logic [DW-1:0] vec_nxt;
  logic          wr_stat;

  assign wr_stat = reg_we && (reg_addr == AW'(OFS_STATUS));

  pic_sense #(.N_IRQ(N_IRQ)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .polar     (polar_q),
    .trig      (trig_q),
    .clr_valid (wr_stat),
    .clr_mask  (reg_wdata),
    .status_o  (status_q)
  );

  assign masked    = status_q & en_q;
  assign crit_pend = masked & crsel_q;
  assign norm_pend = masked & ~crsel_q;

  pic_prio_vec #(.N_IRQ(N_IRQ)) u_prio (
    .pending   (crit_pend),
    .scan_down (vcfg_q[0]),
    .found     (crit_found),
    .rank      (crit_rank)
  );

  assign vec_nxt = crit_found
                 ? ({vcfg_q[DW-1:2], 2'b00} + (DW'(crit_rank) << VEC_STRIDE_LOG2))
                 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      crsel_q <= '0;
      polar_q <= '0;
      trig_q  <= '0;
      vcfg_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(OFS_ENABLE): en_q    <= reg_wdata;
        AW'(OFS_CRSEL):  crsel_q <= reg_wdata;
        AW'(OFS_POLAR):  polar_q <= reg_wdata;
        AW'(OFS_TRIG):   trig_q  <= reg_wdata;
        AW'(OFS_VCFG):   vcfg_q  <= {reg_wdata[DW-1:2], 1'b0, reg_wdata[0]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b0;
      crit_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      norm_q <= |norm_pend;
      crit_q <= |crit_pend;
      vec_q  <= vec_nxt;
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(OFS_STATUS): reg_rdata = status_q;
      AW'(OFS_ENABLE): reg_rdata = en_q;
      AW'(OFS_CRSEL):  reg_rdata = crsel_q;
      AW'(OFS_POLAR):  reg_rdata = polar_q;
      AW'(OFS_TRIG):   reg_rdata = trig_q;
      AW'(OFS_MASKED): reg_rdata = masked;
      AW'(OFS_VECTOR): reg_rdata = vec_q;
      default:         reg_rdata = vcfg_q;
    endcase
  end

  assign irq_norm_o = norm_q;
  assign irq_crit_o = crit_q;

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] irq_in,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [N_IRQ-1:0] reg_wdata,
  input logic             irq_norm_o,
  input logic             irq_crit_o,
  input logic [N_IRQ-1:0] status_q,
  input logic [N_IRQ-1:0] en_q,
  input logic [N_IRQ-1:0] crsel_q,
  input logic [N_IRQ-1:0] polar_q,
  input logic [N_IRQ-1:0] trig_q,
  input logic [N_IRQ-1:0] vcfg_q,
  input logic [N_IRQ-1:0] vec_q
);

  logic [N_IRQ-1:0] in_rev;
  logic [N_IRQ-1:0] clr_now;

  always_comb begin
    for (int k = 0; k < N_IRQ; k++) in_rev[k] = irq_in[N_IRQ-1-k];
  end

  assign clr_now = (reg_we && reg_addr == AW'(0)) ? reg_wdata : '0;

  // R2
  norm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o == (|($past(status_q & en_q & ~crsel_q))));

  // R3
  crit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit_o == (|($past(status_q & en_q & crsel_q))));

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~$past(trig_q) & status_q) == (~$past(trig_q) & $past(in_rev ^ polar_q)));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trig_q) & $past(status_q) & ~$past(clr_now) & ~status_q) == '0);

  // R9
  vcfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(7)) |=>
      (vcfg_q == ($past(reg_wdata) & ~(N_IRQ'(2)))));

  // R10
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_crit_o |-> (vec_q == '0));

endmodule

bind prio_irq_ctrl pic_chk #(.N_IRQ(N_IRQ), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq_norm_o (irq_norm_o),
  .irq_crit_o (irq_crit_o),
  .status_q   (status_q),
  .en_q       (en_q),
  .crsel_q    (crsel_q),
  .polar_q    (polar_q),
  .trig_q     (trig_q),
  .vcfg_q     (vcfg_q),
  .vec_q      (vec_q)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_norm_o;
  logic        irq_crit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit started = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
  );

  // behavioural reference state
  logic [31:0] m_stat, m_en, m_crs, m_pol, m_trg, m_vcfg, m_vec, m_prev;
  logic        m_norm, m_crit;
  logic [31:0] t_corr, t_keep, t_next;

  function automatic logic [31:0] ref_vector(input logic [31:0] cr, input logic [31:0] cfg);
    for (int k = 0; k < 32; k++) begin
      int idx;
      idx = cfg[0] ? 31 - k : k;
      if (cr[idx]) return (cfg & 32'hFFFF_FFFC) + 32'(k * 512);
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_en;
      3'd2: return m_crs;
      3'd3: return m_pol;
      3'd4: return m_trg;
      3'd5: return m_stat & m_en;
      3'd6: return m_vec;
      default: return m_vcfg;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_crs <= '0; m_pol <= '0; m_trg <= '0;
      m_vcfg <= '0; m_vec <= '0; m_prev <= '0; m_norm <= 1'b0; m_crit <= 1'b0;
    end else begin
      for (int n = 0; n < 32; n++) t_corr[31-n] = irq_in[n] ^ m_pol[31-n];
      t_keep = (reg_we && reg_addr == 3'd0) ? (m_stat & ~reg_wdata) : m_stat;
      for (int b = 0; b < 32; b++)
        t_next[b] = m_trg[b] ? (t_keep[b] | (t_corr[b] & ~m_prev[b])) : t_corr[b];
      m_stat <= t_next;
      m_prev <= t_corr;
      m_norm <= |(m_stat & m_en & ~m_crs);
      m_crit <= |(m_stat & m_en & m_crs);
      m_vec  <= ref_vector(m_stat & m_en & m_crs, m_vcfg);
      if (reg_we) begin
        case (reg_addr)
          3'd1: m_en   <= reg_wdata;
          3'd2: m_crs  <= reg_wdata;
          3'd3: m_pol  <= reg_wdata;
          3'd4: m_trg  <= reg_wdata;
          3'd7: m_vcfg <= reg_wdata & 32'hFFFF_FFFD;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      check("R2 R12 normal output", {31'h0, irq_norm_o}, {31'h0, m_norm});
      check("R3 R12 critical output", {31'h0, irq_crit_o}, {31'h0, m_crit});
      case (reg_addr)
        3'd0: check("R1 R4 R5 R6 R7 status", reg_rdata, ref_read(reg_addr));
        3'd5: check("R8 masked status", reg_rdata, ref_read(reg_addr));
        3'd6: check("R10 vector", reg_rdata, ref_read(reg_addr));
        3'd7: check("R9 vector config", reg_rdata, ref_read(reg_addr));
        default: check("R13 config read", reg_rdata, ref_read(reg_addr));
      endcase
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int cycles);
    @(negedge clk); #1;
    reg_addr = a;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); #1;
    irq_in = v;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R11: reset state seen at the ports while reset is held
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      check("R11 reset register", reg_rdata, 32'h0);
    end
    check("R11 reset outputs", {30'h0, irq_norm_o, irq_crit_o}, 32'h0);
    irq_in = '0;
    @(negedge clk); rst_n = 1'b1;
    started = 1'b1;

    // R1 R4: single level lines, reversed bit order
    wr(3'd1, 32'hFFFF_FFFF);
    drive(32'h0000_0001); rd(3'd0, 3);
    drive(32'h8000_0000); rd(3'd5, 3);
    drive(32'h0001_0010); rd(3'd0, 3);
    drive(32'h0);         rd(3'd0, 2);

    // R7: polarity inversion
    wr(3'd3, 32'h0000_00F0);
    rd(3'd0, 3);
    drive(32'h0F00_0000); rd(3'd0, 3);
    wr(3'd3, 32'h0);
    drive(32'h0);

    // R6: clear on level line still active comes back
    drive(32'h0000_0004);
    rd(3'd0, 2);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 2);

    // R5: edge lines latch and hold across clears while high
    drive(32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    drive(32'h0000_0300); rd(3'd0, 2);
    drive(32'h0);         rd(3'd0, 2);
    wr(3'd0, 32'h0040_0000);
    rd(3'd0, 2);
    drive(32'h0000_0100);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 3);
    drive(32'h0); wr(3'd0, 32'hFFFF_FFFF);

    // R9 R10: vector in both directions, bit 1 forced low
    wr(3'd2, 32'h0F0F_00F0);
    wr(3'd7, 32'h1234_5673);
    rd(3'd7, 1);
    drive(32'h0000_1020); rd(3'd6, 3);
    wr(3'd7, 32'hABCD_0002);
    rd(3'd6, 3);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd6, 3);
    // R8: masked read with partial enable
    wr(3'd4, 32'h0);
    drive(32'hFFFF_0000);
    wr(3'd1, 32'h0000_5555);
    rd(3'd5, 2);
    // R13: writes to read-only offsets change nothing
    wr(3'd5, 32'hDEAD_BEEF);
    wr(3'd6, 32'hDEAD_BEEF);
    rd(3'd5, 1); rd(3'd6, 1);
    for (int a = 1; a < 5; a++) rd(3'(a), 1);

    // random mix of lines and register traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (($urandom % 4) == 0) irq_in = $urandom;
      reg_addr = 3'($urandom);
      reg_wdata = $urandom;
      reg_we = (($urandom % 5) == 0);
    end
    @(negedge clk); #1; reg_we = 1'b0;
    repeat (4) @(negedge clk);
    summary();
  end

endmodule